// File: doc/BRIEF.md
# Write-Through Store Queue with Read Bypass

This block sits between a write-through cache and a slower memory below it. Every processor write is taken into a small queue and acknowledged at once, so the processor keeps running while the writes trickle out to memory. Writes leave strictly in the order they arrived, one memory transaction at a time. A queue entry is released only in the cycle memory accepts it.

Processor read misses do not have to wait behind queued writes. An accepted read address is compared against every pending write, and against a write accepted in the same cycle. If nothing matches, the read is sent to memory before any remaining queued write. If something matches, the data of the youngest matching write is returned in the following cycle and memory is not touched. An `empty` output tells a fence or flush sequence when every write has left and no memory read is outstanding.

A four-state machine drives the memory port and the read response:
- `S_IDLE` drains the head write and accepts reads.
- `S_HIT` returns forwarded data for one cycle.
- `S_RD_ISSUE` holds a read request on the memory port until it is accepted.
- `S_RD_WAIT` waits for the memory response.

The transitions are:
- `S_IDLE` goes to `S_HIT` when a read is accepted and matches a pending write.
- `S_IDLE` goes to `S_RD_ISSUE` when a read is accepted and matches nothing.
- `S_HIT` goes back to `S_IDLE` unconditionally.
- `S_RD_ISSUE` goes to `S_RD_WAIT` when memory asserts ready.
- `S_RD_WAIT` goes back to `S_IDLE` when the memory response arrives.

Top module: `wrbuf_bypass`

## Requirements
- R1: While fewer than DEPTH writes are pending (DEPTH defaults to 4), `wr_ready` is high. A write is accepted in any cycle where `wr_valid` and `wr_ready` are both high.
- R2: When DEPTH writes are pending, `wr_ready` is low and no write is accepted until memory takes an entry.
- R3: Pending writes appear on the memory port with `mem_req_we`=1 in exactly their arrival order, with their address and data. Each entry leaves in the cycle where `mem_req_valid` and `mem_req_ready` are both high.
- R4: A read that matches no pending write becomes the very next memory transaction after its acceptance (`mem_req_we`=0), ahead of older pending writes. Its `rd_resp_data` is `mem_rsp_data`, given with `rd_resp_valid` in the cycle `mem_rsp_valid` is high.
- R5: A read whose address matches a pending write gets `rd_resp_valid` exactly one cycle after acceptance. The data is that of the youngest matching write, and no memory read is issued for it.
- R6: A write accepted in the same cycle as a read to the same address counts as older than that read, and its data is forwarded to the read.
- R7: Once `mem_req_valid` is high with `mem_req_ready` low, the request (valid, we, address, data) is held unchanged in the next cycle.
- R8: `empty` is high exactly when no write is pending and no read is waiting on memory.
- R9: Only one read is in progress at a time. `rd_ready` is high only in `S_IDLE`, and only when the memory port does not carry a write that memory refuses in that cycle.
- R10: After reset, `empty`, `wr_ready` and `rd_ready` are high, and `mem_req_valid` and `rd_resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Processor write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Processor read request |
| rd_ready | output | 1 | Read can be accepted this cycle |
| rd_addr | input | AW | Read word address |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |
| empty | output | 1 | No pending write and no read waiting on memory |

## Verification
The first pattern is a back-to-back write burst against a memory that refuses everything. It separates correct stalling at full occupancy from a queue that drops or overwrites entries. Directed reads follow against a partly drained queue: one address written twice tells youngest-match forwarding apart from oldest-match forwarding, and a non-matching read while writes are still queued shows whether the read really overtakes them. A write and a read to the same address offered in the same cycle on an empty queue isolates the same-cycle ordering rule. A long random mix over eight addresses with a memory that accepts irregularly then stresses head-entry matches in the very cycle that entry leaves, and the request hold rule under backpressure.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_HIT      = 2'd1,
        S_RD_ISSUE = 2'd2,
        S_RD_WAIT  = 2'd3
    } wrbuf_state_e;

endpackage

// File: rtl/wrbuf_fifo.sv
module wrbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_addr,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic                       full,
    output logic [CW-1:0]              count,
    output logic [PW-1:0]              head,
    output logic [DEPTH-1:0][AW-1:0]   ent_addr,
    output logic [DEPTH-1:0][DW-1:0]   ent_data
);

    logic [PW-1:0] tail;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full = (count == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= step(tail);
            if (pop)  head <= step(head);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            ent_addr[tail] <= push_addr;
            ent_data[tail] <= push_data;
        end
    end

    // Writer must respect the full flag.
    assert_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // Memory side must never retire an entry that is not there.
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/wrbuf_match.sv
module wrbuf_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [PW-1:0]            head,
    input  logic [CW-1:0]            count,
    input  logic [AW-1:0]            look_addr,
    input  logic                     new_valid,
    input  logic [AW-1:0]            new_addr,
    input  logic [DW-1:0]            new_data,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        int            pos;
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            pos = int'(head) + k;
            if (pos >= DEPTH) pos = pos - DEPTH;
            idx = pos[PW-1:0];
            if ((k < int'(count)) && (ent_addr[idx] == look_addr)) begin
                hit      = 1'b1;
                hit_data = ent_data[idx];
            end
        end
        // A write entering this cycle is younger than every stored entry.
        if (new_valid && (new_addr == look_addr)) begin
            hit      = 1'b1;
            hit_data = new_data;
        end
    end

endmodule

// File: rtl/wrbuf_bypass.sv
module wrbuf_bypass
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wrbuf_state_e state, state_nx;

    logic                     full;
    logic [CW-1:0]            count;
    logic [PW-1:0]            head;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;

    logic          wr_fire, rd_fire, pop;
    logic          fwd_hit;
    logic [DW-1:0] fwd_data;
    logic [AW-1:0] rd_addr_q;
    logic [DW-1:0] hit_data_q;

    assign wr_ready = !full;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_valid && rd_ready;
    assign pop      = mem_req_valid && mem_req_ready && mem_req_we;

    wrbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_fire),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (pop),
        .full      (full),
        .count     (count),
        .head      (head),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    wrbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .head      (head),
        .count     (count),
        .look_addr (rd_addr),
        .new_valid (wr_fire),
        .new_addr  (wr_addr),
        .new_data  (wr_data),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr_q  <= '0;
            hit_data_q <= '0;
        end else if (rd_fire) begin
            rd_addr_q  <= rd_addr;
            hit_data_q <= fwd_data;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (rd_fire) state_nx = fwd_hit ? S_HIT : S_RD_ISSUE;
            S_HIT:      state_nx = S_IDLE;
            S_RD_ISSUE: if (mem_req_ready) state_nx = S_RD_WAIT;
            S_RD_WAIT:  if (mem_rsp_valid) state_nx = S_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b1;
        mem_req_addr  = ent_addr[head];
        mem_req_wdata = ent_data[head];
        rd_resp_valid = 1'b0;
        rd_resp_data  = '0;
        unique case (state)
            S_IDLE: begin
                mem_req_valid = (count != '0);
            end
            S_HIT: begin
                mem_req_valid = (count != '0);
                rd_resp_valid = 1'b1;
                rd_resp_data  = hit_data_q;
            end
            S_RD_ISSUE: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b0;
                mem_req_addr  = rd_addr_q;
                mem_req_wdata = '0;
            end
            S_RD_WAIT: begin
                mem_req_we    = 1'b0;
                mem_req_addr  = rd_addr_q;
                mem_req_wdata = '0;
                rd_resp_valid = mem_rsp_valid;
                rd_resp_data  = mem_rsp_data;
            end
        endcase
    end

    // A read may only enter when it cannot force withdrawal of a refused write.
    assign rd_ready = (state == S_IDLE) && !(mem_req_valid && !mem_req_ready);

    assign empty = (count == '0) && ((state == S_IDLE) || (state == S_HIT));

    assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
            && $stable(mem_req_addr) && $stable(mem_req_wdata));

    assert_fwd_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire && fwd_hit |=> rd_resp_valid && !(mem_req_valid && !mem_req_we));

    assert_miss_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire && !fwd_hit |=> mem_req_valid && !mem_req_we);

    assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !mem_req_valid);

    assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_valid |-> !rd_ready);

endmodule

// File: tb/test_wrbuf_bypass.sv
`timescale 1ns/1ps
module test_wrbuf_bypass;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid, wr_ready;
    logic [31:0] wr_addr, wr_data;
    logic        rd_valid, rd_ready;
    logic [31:0] rd_addr;
    logic        rd_resp_valid;
    logic [31:0] rd_resp_data;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        empty;

    always #2.5 clk = ~clk;

    wrbuf_bypass #(.DEPTH(DEPTH), .AW(32), .DW(32)) i_wrbuf_bypass (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .empty(empty)
    );

    int n_cmp = 0;
    int n_err = 0;
    bit finished = 0;

    // Reference model state
    logic [31:0] q_a[$];
    logic [31:0] q_d[$];
    logic [31:0] mem_arr [16];
    bit          mem_rd_pending = 0;
    bit          rd_issued = 0;
    bit          bypass_wait = 0;
    bit          fwd_due = 0;
    logic [31:0] exp_rd_data = '0;
    logic [31:0] exp_rd_addr = '0;
    string       fwd_tag = "R5";
    int          rsp_cnt = 0;
    logic [31:0] rsp_dat = '0;
    logic [31:0] rs = 32'h1357_9bdf;
    bit          prev_stall = 0;
    logic        prev_we = 1'b0;
    logic [31:0] prev_addr = '0, prev_wdata = '0;
    int          wn = 0, rn = 0;
    int n_fwd = 0, n_same = 0, n_byp = 0, n_full = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
    endtask

    function automatic logic [31:0] dir_waddr(input int n);
        case (n % 10)
            0: return 32'd1;  1: return 32'd2;  2: return 32'd3;  3: return 32'd1;
            4: return 32'd5;  5: return 32'd6;  6: return 32'd4;  7: return 32'd2;
            8: return 32'd8;  default: return 32'd10;
        endcase
    endfunction

    function automatic logic [31:0] dir_raddr(input int n);
        case (n)
            0: return 32'd1;  1: return 32'd9;  2: return 32'd3;
            3: return 32'd12; default: return 32'd6;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) mem_arr[i] = 32'hA000_0000 + i;
        wr_valid = 0; wr_addr = '0; wr_data = '0;
        rd_valid = 0; rd_addr = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(empty == 1'b1, "R10 empty", 32'(empty), 32'd1);
        check(wr_ready == 1'b1, "R10 wr_ready", 32'(wr_ready), 32'd1);
        check(rd_ready == 1'b1, "R10 rd_ready", 32'(rd_ready), 32'd1);
        check(mem_req_valid == 1'b0, "R10 mem_req_valid", 32'(mem_req_valid), 32'd0);
        check(rd_resp_valid == 1'b0, "R10 rd_resp_valid", 32'(rd_resp_valid), 32'd0);

        for (int c = 0; c < 2110; c++) begin
            bit wf, rf, mf, exp_resp, m_hit, pop_now;
            logic [31:0] m_dat;
            string m_tag;
            @(negedge clk);
            // Memory response model: fixed two-cycle read latency.
            mem_rsp_valid = (rsp_cnt == 1);
            mem_rsp_data  = (rsp_cnt == 1) ? rsp_dat : 32'h0;
            if (rsp_cnt > 0) rsp_cnt--;

            // Stimulus
            if (c < 8) begin
                wr_valid = 1; wr_addr = dir_waddr(wn); wr_data = 32'h1000_0000 + wn;
                rd_valid = 0; mem_req_ready = 0;
            end else if (c < 41) begin
                wr_valid = (wn < 10); wr_addr = dir_waddr(wn); wr_data = 32'h1000_0000 + wn;
                rd_valid = (rn < 5); rd_addr = dir_raddr(rn);
                mem_req_ready = (c % 3 != 0);
            end else if (c < 61) begin
                wr_valid = 0; rd_valid = 0; mem_req_ready = 1;
            end else if (c == 61) begin
                wr_valid = 1; wr_addr = 32'd7; wr_data = 32'h7777_0007;
                rd_valid = 1; rd_addr = 32'd7; mem_req_ready = 1;
            end else if (c < 64) begin
                wr_valid = 0; rd_valid = 0; mem_req_ready = 1;
            end else if (c < 2064) begin
                rnd(); wr_valid = rs[0]; wr_addr = {29'd0, rs[3:1]}; wr_data = rs ^ 32'h5a5a_0000;
                rnd(); rd_valid = rs[0] & rs[1]; rd_addr = {29'd0, rs[4:2]};
                rnd(); mem_req_ready = (rs[2:0] > 3'd1);
            end else begin
                wr_valid = 0; rd_valid = 0; mem_req_ready = 1;
            end
            #1;

            wf = wr_valid && wr_ready;
            rf = rd_valid && rd_ready;
            mf = mem_req_valid && mem_req_ready;

            // Status and handshake outputs against the model
            check(empty == (q_a.size() == 0 && !mem_rd_pending), "R8 empty", 32'(empty),
                  32'(q_a.size() == 0 && !mem_rd_pending));
            if (q_a.size() >= DEPTH) begin
                n_full++;
                check(wr_ready == 1'b0, "R2 wr_ready at full", 32'(wr_ready), 32'd0);
            end else
                check(wr_ready == 1'b1, "R1 wr_ready below full", 32'(wr_ready), 32'd1);
            check(rd_ready == (!(fwd_due || mem_rd_pending) && !(q_a.size() > 0 && !mem_req_ready)),
                  "R9 rd_ready", 32'(rd_ready),
                  32'(!(fwd_due || mem_rd_pending) && !(q_a.size() > 0 && !mem_req_ready)));
            if (prev_stall)
                check(mem_req_valid && mem_req_we == prev_we && mem_req_addr == prev_addr &&
                      mem_req_wdata == prev_wdata, "R7 request held", mem_req_addr, prev_addr);

            // Read response
            exp_resp = fwd_due || mem_rsp_valid;
            check(rd_resp_valid == exp_resp, fwd_due ? fwd_tag : "R4 resp valid",
                  32'(rd_resp_valid), 32'(exp_resp));
            if (exp_resp && rd_resp_valid)
                check(rd_resp_data == exp_rd_data, fwd_due ? fwd_tag : "R4 resp data",
                      rd_resp_data, exp_rd_data);
            if (mem_rsp_valid) begin
                mem_rd_pending = 0; rd_issued = 0;
            end
            fwd_due = 0;

            // Memory transactions
            pop_now = 0;
            if (mf && mem_req_we) begin
                check(!bypass_wait, "R4 write overtook read", mem_req_addr, exp_rd_addr);
                if (q_a.size() == 0)
                    check(0, "R3 write with empty queue", mem_req_addr, 32'hx);
                else begin
                    check(mem_req_addr == q_a[0], "R3 drain addr", mem_req_addr, q_a[0]);
                    check(mem_req_wdata == q_d[0], "R3 drain data", mem_req_wdata, q_d[0]);
                    mem_arr[mem_req_addr[3:0]] = mem_req_wdata;
                    pop_now = 1;
                end
            end else if (mf && !mem_req_we) begin
                check(mem_rd_pending && !rd_issued, "R5 unexpected memory read",
                      mem_req_addr, exp_rd_addr);
                check(mem_req_addr == exp_rd_addr, "R4 read addr", mem_req_addr, exp_rd_addr);
                rd_issued = 1; bypass_wait = 0;
                rsp_cnt = 2; rsp_dat = mem_arr[mem_req_addr[3:0]];
            end

            // Read acceptance: search includes an entry leaving this cycle
            if (rf) begin
                m_hit = 0; m_dat = '0; m_tag = "R5 forward";
                for (int i = 0; i < q_a.size(); i++)
                    if (q_a[i] == rd_addr) begin m_hit = 1; m_dat = q_d[i]; end
                if (wf && wr_addr == rd_addr) begin
                    m_hit = 1; m_dat = wr_data; m_tag = "R6 same-cycle forward"; n_same++;
                end
                if (m_hit) begin
                    fwd_due = 1; exp_rd_data = m_dat; fwd_tag = m_tag; n_fwd++;
                end else begin
                    mem_rd_pending = 1; bypass_wait = 1; exp_rd_addr = rd_addr;
                    exp_rd_data = mem_arr[rd_addr[3:0]];
                    if (q_a.size() > (pop_now ? 1 : 0)) n_byp++;
                end
                if (c < 41) rn++;
            end
            if (pop_now) begin q_a.pop_front(); q_d.pop_front(); end
            if (wf) begin
                q_a.push_back(wr_addr); q_d.push_back(wr_data);
                if (c < 41) wn++;
            end

            prev_stall = mem_req_valid && !mem_req_ready;
            prev_we = mem_req_we; prev_addr = mem_req_addr; prev_wdata = mem_req_wdata;
        end

        check(empty == 1'b1 && q_a.size() == 0, "R8 final drain", 32'(empty), 32'd1);
        check(n_full > 0, "R2 full reached", n_full, 32'd1);
        check(n_fwd > 0, "R5 forward seen", n_fwd, 32'd1);
        check(n_same > 0, "R6 same-cycle seen", n_same, 32'd1);
        check(n_byp > 0, "R4 bypass seen", n_byp, 32'd1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule